// File: doc/BRIEF.md
# Single-Slope PWM Timer with Two Compare Channels

This block is an up-counting timer that makes pulse-width-modulated waveforms. A free-running prescaler divides the system clock into ticks. On each tick the counter steps up by one until it reaches the period limit (TOP), and on the next tick it returns to zero. Two compare channels, A and B, each drive one output pin. A pin is high or low depending on whether the count has passed that channel's compare value. Each channel has its own polarity setting.

Software configures the block through a three-register write port. The control register sets the channel output modes, the TOP source and the clock divisor. The other two registers hold the two compare values. TOP is either the all-ones count or the active compare value of channel A. In the second case channel A serves as the period register, and only channel B produces a waveform.

Compare writes go to shadow registers. They move to the active registers when the counter wraps to zero, or at once while the timer is stopped. This keeps the period free of partial pulses.

Top module: `fast_pwm_timer`

## Requirements
- R1: On every tick the count rises by one. On the tick where the count equals TOP it returns to 0. A tick that finds the count at all-ones also returns it to 0.
- R2: When control bit 4 is 0, TOP is 255, the period is 256 ticks, and both pins carry waveforms.
- R3: When control bit 4 is 1, TOP is the active compare value of channel A and the period is that value plus one ticks. pwm_a stays low whatever channel A's mode is.
- R4: Control bits [7:5] select the tick rate: 001 ticks every clock, 010 every 8 clocks, 011 every 64, 100 every 256, 101 every 1024. Codes 000, 110 and 111 stop the counter. While stopped, the prescaler is cleared, so the first tick after a start comes a full divisor of clocks after the write.
- R5: In mode 10 (channel A uses control bits [1:0], channel B uses bits [3:2]), the pin is high while the count is at or below the compare value. The high time is therefore compare+1 ticks: 191 gives 192 of 256.
- R6: In mode 11 the pin is the complement of mode 10. It rises after the compare match and falls at the wrap, so the high time is TOP minus compare ticks: 63 gives 192 of 256.
- R7: In modes 00 and 01 the pin is held low.
- R8: Register address 1 writes channel A's compare value and address 2 writes channel B's. While running, a written value takes effect only on the wrap to 0. While stopped, it takes effect at once.
- R9: A compare value equal to or above TOP never produces an edge. In mode 10 the pin stays high; in mode 11 it stays low.
- R10: After reset the count is 0, all registers are 0, the timer is stopped, and both pins are low.
- R11: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare A, 2 compare B |
| wr_data | input | CW | Write data; control uses bits [7:0] |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| cnt_o | output | CW | Current count |

## Verification
The bench builds the timer with the default 8-bit count (CW = 8). With that width a full fixed period of 256 ticks fits easily into the run, as does the slowest divisor of 1024 clocks per tick. Both limits of the compare range are therefore reachable: a compare of 0, a compare equal to TOP, a compare above a short variable TOP, and a TOP of 0. The vector table measures the period and the high times of both pins over one whole period. Directed tests then cover the divisors, the stop codes, mid-period rewrites of the compare and TOP values, and the unused address.

// File: rtl/fast_pwm_timer.sv
module fast_pwm_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic [CW-1:0] cnt_o
);

  localparam int PW = 10;
  localparam logic [CW-1:0] MAXV = '1;

  logic [7:0]    ctrl_q, ctrl_n;
  logic [CW-1:0] sha_q, shb_q, sha_n, shb_n;
  logic [CW-1:0] acta_q, actb_q, acta_n, actb_n;
  logic [CW-1:0] cnt_q, cnt_n, top;
  logic [PW-1:0] pre_q, mask;
  logic          run, tick, wrap, load;
  logic          pa_n, pb_n;

  assign ctrl_n = (wr_en && wr_addr == 2'd0) ? wr_data[7:0] : ctrl_q;
  assign sha_n  = (wr_en && wr_addr == 2'd1) ? wr_data : sha_q;
  assign shb_n  = (wr_en && wr_addr == 2'd2) ? wr_data : shb_q;

  always_comb begin
    run  = 1'b1;
    mask = '0;
    case (ctrl_q[7:5])
      3'd1: mask = PW'(0);
      3'd2: mask = PW'(7);
      3'd3: mask = PW'(63);
      3'd4: mask = PW'(255);
      3'd5: mask = PW'(1023);
      default: run = 1'b0;
    endcase
  end

  assign tick = run && ((pre_q & mask) == mask);
  assign top  = ctrl_q[4] ? acta_q : MAXV;
  assign wrap = tick && (cnt_q == top || cnt_q == MAXV);
  assign load = wrap || !run;

  assign cnt_n  = !tick ? cnt_q : (wrap ? '0 : cnt_q + CW'(1));
  assign acta_n = load ? sha_n : acta_q;
  assign actb_n = load ? shb_n : actb_q;

  assign pa_n = (!ctrl_n[4] && ctrl_n[1]) ? ((cnt_n <= acta_n) ^ ctrl_n[0]) : 1'b0;
  assign pb_n = ctrl_n[3] ? ((cnt_n <= actb_n) ^ ctrl_n[2]) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sha_q  <= '0;
      shb_q  <= '0;
      acta_q <= '0;
      actb_q <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      pwm_a  <= 1'b0;
      pwm_b  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      sha_q  <= sha_n;
      shb_q  <= shb_n;
      acta_q <= acta_n;
      actb_q <= actb_n;
      cnt_q  <= cnt_n;
      pre_q  <= run ? pre_q + PW'(1) : '0;
      pwm_a  <= pa_n;
      pwm_b  <= pb_n;
    end
  end

  assign cnt_o = cnt_q;

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == top) |=> (cnt_q == '0));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != top && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  p_a_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |-> !pwm_a);

  p_b_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[3] |-> !pwm_b);

  p_a_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |-> !pwm_a);

  p_buf_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(actb_q) |-> (cnt_q == '0 || !$past(run)));

  p_buf_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acta_q) |-> (cnt_q == '0 || !$past(run)));

endmodule

// File: tb/fast_pwm_timer_tb.sv
module fast_pwm_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_a, pwm_b;
  logic [7:0] cnt_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fast_pwm_timer #(.CW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt_o(cnt_o)
  );

  // ctrl, compare A, compare B, period, high A, high B
  localparam int NV = 11;
  localparam int VEC [NV][6] = '{
    '{8'h2A, 191,  63, 256, 192,  64},
    '{8'h2F,  63, 191, 256, 192,  64},
    '{8'h22,   0, 100, 256,   1,   0},
    '{8'h2D,  10, 255, 256,   0,   0},
    '{8'h2A, 255,   0, 256, 256,   1},
    '{8'h3A, 200, 191, 201,   0, 192},
    '{8'h3C, 200,  63, 201,   0, 137},
    '{8'h3A,  99, 150, 100,   0, 100},
    '{8'h3C,  99, 150, 100,   0,   0},
    '{8'h3A,   0,   0,   1,   0,   1},
    '{8'h3B,  50,  20,  51,   0,  21}
  };
  string tg [NV];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int per, output int ha, output int hb);
    per = 0; ha = 0; hb = 0;
    do begin
      ha += int'(pwm_a);
      hb += int'(pwm_b);
      per++;
      @(negedge clk);
    end while (cnt_o != 8'd0 && per < 3000);
  endtask

  task automatic first_tick(input logic [7:0] ctrl, input int exp, input string req);
    int n;
    do_reset();
    wr(2'd0, ctrl);
    n = 0;
    while (cnt_o == 8'd0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(req, n, exp);
  endtask

  task automatic wait_cnt(input logic [7:0] v, output bit hit);
    int n;
    n = 0;
    while (cnt_o != v && n < 3000) begin
      @(negedge clk);
      n++;
    end
    hit = (cnt_o == v);
  endtask

  initial begin
    int per, ha, hb;
    bit hit;
    logic [7:0] c0;
    tg = '{"R2 R5", "R2 R6", "R5 R7", "R7 R9", "R5 R9", "R3 R5",
           "R3 R6", "R3 R9", "R3 R9", "R1 R3", "R3 R7"};

    // R10: reset state
    repeat (2) @(negedge clk);
    chk("R10 count", int'(cnt_o), 0);
    chk("R10 pwm_a", int'(pwm_a), 0);
    chk("R10 pwm_b", int'(pwm_b), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 stopped", int'(cnt_o), 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd1, 8'(VEC[i][1]));
      wr(2'd2, 8'(VEC[i][2]));
      wr(2'd0, 8'(VEC[i][0]));
      measure(per, ha, hb);
      chk({tg[i], " period"}, per, VEC[i][3]);
      chk({tg[i], " high A"}, ha, VEC[i][4]);
      chk({tg[i], " high B"}, hb, VEC[i][5]);
      measure(per, ha, hb);
      chk({tg[i], " R1 second period"}, per, VEC[i][3]);
    end

    // R4: divisors
    first_tick(8'h40, 8, "R4 div8");
    first_tick(8'h60, 64, "R4 div64");
    first_tick(8'h80, 256, "R4 div256");
    first_tick(8'hA0, 1024, "R4 div1024");
    first_tick(8'h20, 1, "R4 div1");

    // R4 stop codes, R8 immediate load while stopped
    do_reset();
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h02);
    chk("R8 stopped load", int'(pwm_a), 1);
    repeat (2000) @(negedge clk);
    chk("R4 code 000 stops", int'(cnt_o), 0);
    wr(2'd0, 8'hC2);
    repeat (2000) @(negedge clk);
    chk("R4 code 110 stops", int'(cnt_o), 0);
    wr(2'd0, 8'h22);
    repeat (5) @(negedge clk);
    c0 = cnt_o;
    wr(2'd0, 8'hE2);
    c0 = cnt_o;
    repeat (500) @(negedge clk);
    chk("R4 code 111 stops", int'(cnt_o), int'(c0));

    // R8: compare B rewritten mid-period
    do_reset();
    wr(2'd1, 8'd191);
    wr(2'd2, 8'd63);
    wr(2'd0, 8'h2A);
    wait_cnt(8'd10, hit);
    wr(2'd2, 8'd200);
    wait_cnt(8'd100, hit);
    chk("R8 old compare kept", int'(pwm_b), 0);
    wait_cnt(8'd0, hit);
    wait_cnt(8'd100, hit);
    chk("R8 new compare at wrap", int'(pwm_b), 1);

    // R8: TOP rewritten mid-period
    do_reset();
    wr(2'd1, 8'd200);
    wr(2'd2, 8'd20);
    wr(2'd0, 8'h3A);
    wait_cnt(8'd10, hit);
    wr(2'd1, 8'd100);
    wait_cnt(8'd150, hit);
    chk("R8 old TOP kept", int'(hit), 1);
    wait_cnt(8'd0, hit);
    measure(per, ha, hb);
    chk("R8 new TOP period", per, 101);

    // R11: address 3 ignored
    do_reset();
    wr(2'd1, 8'd191);
    wr(2'd2, 8'd63);
    wr(2'd0, 8'h0A);
    wr(2'd3, 8'hFF);
    repeat (50) @(negedge clk);
    chk("R11 count", int'(cnt_o), 0);
    chk("R11 pwm_a", int'(pwm_a), 1);
    chk("R11 pwm_b", int'(pwm_b), 1);
    wr(2'd0, 8'h2A);
    measure(per, ha, hb);
    chk("R11 high A", ha, 192);
    chk("R11 high B", hb, 64);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule